// File: doc/BRIEF.md
# Token-Gated Rendezvous Channel

This block is a blocking point-to-point channel. It joins one sending process and one receiving process, and each process is started by a one-cycle token pulse from its parent. The sender takes its token and offers a value on the channel. The receiver takes its token and accepts that value. The receiver answers with a one-cycle acknowledge, and both sides then hand their tokens back to their parents. A side never returns its token before the transfer has finished, so a parent can order its processes by watching the token returns.

A plain wiring stage sits between the two ends. It forwards the offered value toward the receiver and the acknowledge back toward the sender, so a buffered channel can later take its place without changing either end. The value is a signed word whose width is a parameter (8 bits by default). The received word stays on the receiver output until the next transfer overwrites it. If only one side ever becomes active, the channel stays blocked: nothing moves and no token comes back.

Top module: `rv_rendezvous`

## Requirements
- R1: After synchronous reset, `wr_tok_out`, `rd_tok_out`, `ch_vld`, `ch_ack` and `rd_vld_out` are 0 and `rd_data_out` is 0.
- R2: From the cycle after the sender samples `wr_tok_in`=1, and for as long as it sees no acknowledge, `ch_vld` is 1. `ch_data` equals the `wr_data_in` value that was sampled at the previous clock edge, so it follows a changing input with one cycle of delay.
- R3: A receiver holding its token while `ch_vld` is 1 drives `ch_ack`=1 and `rd_tok_out`=1 in that same cycle. Both are single-cycle pulses.
- R4: The sender returns its token (`wr_tok_out`=1) for exactly one cycle, in the cycle right after `ch_ack`. In that cycle `ch_vld` is 0.
- R5: The value transferred appears on `rd_data_out`, with `rd_vld_out`=1, in the cycle after the acknowledge. It stays there until the next transfer.
- R6: While the receiver has no token, `ch_ack` stays 0 and `rd_data_out` does not change, even while the sender is offering a value.
- R7: If the sender holds a token and the receiver never gets one, `ch_ack` never rises and `wr_tok_out` never rises. The sender keeps offering and stays blocked.
- R8: If the receiver holds a token and no value is offered, `rd_tok_out` and `ch_ack` stay 0 and `rd_data_out` keeps its value.
- R9: When the second side arrives late, the transfer completes. The receiver's token comes back in the cycle after it was taken, and the sender's token comes back one cycle after that.
- R10: Data are two's-complement signed words of parameter width `DATA_W` (default 8). The extreme values -128 and 127 pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_tok_in | input | 1 | Token pulse that starts the sender |
| wr_data_in | input | DATA_W | Value to send (signed) |
| wr_tok_out | output | 1 | Sender hands its token back |
| rd_tok_in | input | 1 | Token pulse that starts the receiver |
| rd_tok_out | output | 1 | Receiver hands its token back |
| rd_vld_out | output | 1 | At least one value has been received |
| rd_data_out | output | DATA_W | Last received value (signed) |
| ch_vld | output | 1 | Channel carries an offered value |
| ch_data | output | DATA_W | Offered value on the channel |
| ch_ack | output | 1 | Acknowledge from the receiver |

## Verification
The bench first starts both tokens in the same cycle, as a parallel composition would. It does this with a negative word and with both extreme words, which shows the exact cycle of each token return and whether the sign is kept. Next it starts only the sender, changes the input while the sender waits, and only later starts the receiver. This separates a correctly blocked channel from one that leaks tokens, and it shows the data tracking and the late completion. A receiver-first run tests the opposite blocking case. Finally, two channel instances are chained in sequence on both sides, with a one-cycle token relay between them. This checks the order in which the four tokens return and that each chain delivers its own value.

// File: rtl/rv_pkg.sv
package rv_pkg;

    localparam int RV_DEF_W = 8;

    // Sender control flags
    typedef struct packed {
        logic have;   // token held
        logic seen;   // acknowledge observed
    } snd_flags_t;

    // Receiver control flags
    typedef struct packed {
        logic have;   // token held
        logic got;    // at least one value captured
    } rcv_flags_t;

    function automatic logic snd_offering(snd_flags_t f);
        return f.have & ~f.seen;
    endfunction

    function automatic logic snd_closing(snd_flags_t f);
        return f.have & f.seen;
    endfunction

endpackage

// File: rtl/rv_writer.sv
module rv_writer
    import rv_pkg::*;
#(
    parameter int DATA_W = RV_DEF_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tok_in,
    output logic                     tok_out,
    input  logic                     ack_in,
    input  logic signed [DATA_W-1:0] data_in,
    output logic                     offer_vld,
    output logic signed [DATA_W-1:0] offer_data
);

    snd_flags_t              flg_q, flg_d;
    logic signed [DATA_W-1:0] val_q;

    always_comb begin
        flg_d     = flg_q;
        tok_out   = 1'b0;
        offer_vld = 1'b0;
        if (snd_offering(flg_q)) begin
            flg_d.have = 1'b1;
            flg_d.seen = ack_in;
            offer_vld  = 1'b1;
        end else if (snd_closing(flg_q)) begin
            flg_d   = '0;
            tok_out = 1'b1;
        end else begin
            flg_d.have = tok_in;
            flg_d.seen = ack_in;
        end
    end

    assign offer_data = offer_vld ? val_q : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q <= '0;
            val_q <= '0;
        end else begin
            flg_q <= flg_d;
            val_q <= data_in;
        end
    end

endmodule

// File: rtl/rv_link.sv
module rv_link
    import rv_pkg::*;
#(
    parameter int DATA_W = RV_DEF_W
) (
    input  logic                     up_vld,
    input  logic signed [DATA_W-1:0] up_data,
    output logic                     up_ack,
    output logic                     dn_vld,
    output logic signed [DATA_W-1:0] dn_data,
    input  logic                     dn_ack
);

    assign dn_vld  = up_vld;
    assign dn_data = up_data;
    assign up_ack  = dn_ack;

endmodule

// File: rtl/rv_reader.sv
module rv_reader
    import rv_pkg::*;
#(
    parameter int DATA_W = RV_DEF_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tok_in,
    output logic                     tok_out,
    input  logic                     in_vld,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     ack_out,
    output logic                     out_vld,
    output logic signed [DATA_W-1:0] out_data
);

    rcv_flags_t               flg_q, flg_d;
    logic signed [DATA_W-1:0] val_q, val_d;
    logic                     take;

    assign take    = flg_q.have & in_vld;
    assign ack_out = take;
    assign tok_out = take;

    always_comb begin
        flg_d = flg_q;
        val_d = val_q;
        if (take) begin
            flg_d.have = 1'b0;
            flg_d.got  = 1'b1;
            val_d      = in_data;
        end else if (!flg_q.have) begin
            flg_d.have = tok_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q <= '0;
            val_q <= '0;
        end else begin
            flg_q <= flg_d;
            val_q <= val_d;
        end
    end

    assign out_vld  = flg_q.got;
    assign out_data = val_q;

endmodule

// File: rtl/rv_rendezvous.sv
module rv_rendezvous
    import rv_pkg::*;
#(
    parameter int DATA_W = RV_DEF_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_tok_in,
    input  logic signed [DATA_W-1:0] wr_data_in,
    output logic                     wr_tok_out,
    input  logic                     rd_tok_in,
    output logic                     rd_tok_out,
    output logic                     rd_vld_out,
    output logic signed [DATA_W-1:0] rd_data_out,
    output logic                     ch_vld,
    output logic signed [DATA_W-1:0] ch_data,
    output logic                     ch_ack
);

    logic                     snd_vld, snd_ack, rcv_vld, rcv_ack;
    logic signed [DATA_W-1:0] snd_data, rcv_data;

    rv_writer #(.DATA_W(DATA_W)) u_snd (
        .clk        (clk),
        .rst        (rst),
        .tok_in     (wr_tok_in),
        .tok_out    (wr_tok_out),
        .ack_in     (snd_ack),
        .data_in    (wr_data_in),
        .offer_vld  (snd_vld),
        .offer_data (snd_data)
    );

    rv_link #(.DATA_W(DATA_W)) u_link (
        .up_vld  (snd_vld),
        .up_data (snd_data),
        .up_ack  (snd_ack),
        .dn_vld  (rcv_vld),
        .dn_data (rcv_data),
        .dn_ack  (rcv_ack)
    );

    rv_reader #(.DATA_W(DATA_W)) u_rcv (
        .clk      (clk),
        .rst      (rst),
        .tok_in   (rd_tok_in),
        .tok_out  (rd_tok_out),
        .in_vld   (rcv_vld),
        .in_data  (rcv_data),
        .ack_out  (rcv_ack),
        .out_vld  (rd_vld_out),
        .out_data (rd_data_out)
    );

    assign ch_vld  = snd_vld;
    assign ch_data = snd_data;
    assign ch_ack  = snd_ack;

endmodule

// File: rtl/rv_rendezvous_chk.sv
module rv_rendezvous_chk #(
    parameter int DATA_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_tok_out,
    input logic                     rd_tok_out,
    input logic                     rd_vld_out,
    input logic signed [DATA_W-1:0] rd_data_out,
    input logic                     ch_vld,
    input logic signed [DATA_W-1:0] ch_data,
    input logic                     ch_ack
);

    // R4
    snd_ret_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ch_ack |=> wr_tok_out);

    // R4
    snd_ret_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_tok_out |=> !wr_tok_out);

    // R4
    snd_ret_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        wr_tok_out |-> !ch_vld);

    // R3
    rcv_ret_needs_offer_chk: assert property (@(posedge clk) disable iff (rst)
        rd_tok_out |-> (ch_vld && ch_ack));

    // R5
    rcv_load_chk: assert property (@(posedge clk) disable iff (rst)
        rd_tok_out |=> (rd_vld_out && rd_data_out == $past(ch_data)));

    // R6
    rcv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_tok_out |=> $stable(rd_data_out));

    // R7
    ack_needs_offer_chk: assert property (@(posedge clk) disable iff (rst)
        ch_ack |-> ch_vld);

endmodule

bind rv_rendezvous rv_rendezvous_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_tok_out  (wr_tok_out),
    .rd_tok_out  (rd_tok_out),
    .rd_vld_out  (rd_vld_out),
    .rd_data_out (rd_data_out),
    .ch_vld      (ch_vld),
    .ch_data     (ch_data),
    .ch_ack      (ch_ack)
);

// File: tb/rv_rendezvous_bench.sv
`timescale 1ns/1ps
module rv_rendezvous_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // instance A
    logic              a_wr_tok = 0, a_rd_tok = 0;
    logic signed [7:0] a_wr_data = 0;
    logic              a_wr_ret, a_rd_ret, a_rd_vld, a_vld, a_ack;
    logic signed [7:0] a_rd_data, a_ch_data;

    // instance B (sequential chain partner)
    logic              seq_mode = 0;
    logic              wr_relay_q = 0, rd_relay_q = 0;
    logic signed [7:0] b_wr_data = 0;
    logic              b_wr_ret, b_rd_ret, b_rd_vld, b_vld, b_ack;
    logic signed [7:0] b_rd_data, b_ch_data;
    logic              b_wr_tok, b_rd_tok;

    assign b_wr_tok = seq_mode & wr_relay_q;
    assign b_rd_tok = seq_mode & rd_relay_q;

    // one-cycle token relay of a sequential composer
    always @(posedge clk) begin
        wr_relay_q <= a_wr_ret;
        rd_relay_q <= a_rd_ret;
    end

    rv_rendezvous u_rv_rendezvous (
        .clk(clk), .rst(rst),
        .wr_tok_in(a_wr_tok), .wr_data_in(a_wr_data), .wr_tok_out(a_wr_ret),
        .rd_tok_in(a_rd_tok), .rd_tok_out(a_rd_ret),
        .rd_vld_out(a_rd_vld), .rd_data_out(a_rd_data),
        .ch_vld(a_vld), .ch_data(a_ch_data), .ch_ack(a_ack)
    );

    rv_rendezvous u_rv_rendezvous_b (
        .clk(clk), .rst(rst),
        .wr_tok_in(b_wr_tok), .wr_data_in(b_wr_data), .wr_tok_out(b_wr_ret),
        .rd_tok_in(b_rd_tok), .rd_tok_out(b_rd_ret),
        .rd_vld_out(b_rd_vld), .rd_data_out(b_rd_data),
        .ch_vld(b_vld), .ch_data(b_ch_data), .ch_ack(b_ack)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(a_wr_ret == 0 && a_rd_ret == 0, "R1 token returns", a_wr_ret + a_rd_ret, 0);
        chk(a_vld == 0 && a_ack == 0, "R1 channel idle", a_vld + a_ack, 0);
        chk(a_rd_vld == 0 && a_rd_data == 0, "R1 reader value", a_rd_data, 0);
    endtask

    // both tokens issued together, as by a parallel composer
    task automatic t_parallel(input logic signed [7:0] d, input string tag);
        a_wr_data = d; a_wr_tok = 1; a_rd_tok = 1;
        @(negedge clk);
        a_wr_tok = 0; a_rd_tok = 0;
        chk(a_vld == 1 && a_ch_data == d, {"R2 offer ", tag}, a_ch_data, d);
        chk(a_ack == 1 && a_rd_ret == 1, "R3 ack and reader return", a_ack + a_rd_ret, 2);
        chk(a_wr_ret == 0, "R4 no early sender return", a_wr_ret, 0);
        @(negedge clk);
        chk(a_wr_ret == 1 && a_vld == 0, "R4 sender return", a_wr_ret, 1);
        chk(a_rd_ret == 0 && a_ack == 0, "R3 single pulse", a_rd_ret + a_ack, 0);
        chk(a_rd_vld == 1 && a_rd_data == d, {"R5 R10 received ", tag}, a_rd_data, d);
        @(negedge clk);
        chk(a_wr_ret == 0, "R4 one-cycle return", a_wr_ret, 0);
        repeat (4) @(negedge clk);
        chk(a_rd_data == d && a_rd_vld == 1, "R5 value held", a_rd_data, d);
    endtask

    // sender alone blocks, then a late reader releases it
    task automatic t_deadlock();
        logic signed [7:0] prev;
        int bad_ret, bad_ack, bad_vld;
        prev = a_rd_data;
        bad_ret = 0; bad_ack = 0; bad_vld = 0;
        a_wr_data = 33; a_wr_tok = 1;
        @(negedge clk);
        a_wr_tok = 0;
        chk(a_ch_data == 33, "R2 first offer", a_ch_data, 33);
        for (int i = 0; i < 20; i++) begin
            if (i == 10) a_wr_data = 44;
            @(negedge clk);
            if (a_wr_ret) bad_ret++;
            if (a_ack) bad_ack++;
            if (!a_vld) bad_vld++;
            if (i == 10) chk(a_ch_data == 44, "R2 offer tracks input", a_ch_data, 44);
        end
        chk(bad_ret == 0, "R7 no sender return", bad_ret, 0);
        chk(bad_ack == 0 && bad_vld == 0, "R7 blocked offer", bad_ack + bad_vld, 0);
        chk(a_rd_data == prev, "R6 reader value untouched", a_rd_data, prev);
        a_rd_tok = 1;
        @(negedge clk);
        a_rd_tok = 0;
        chk(a_rd_ret == 1 && a_ack == 1, "R9 late reader returns", a_rd_ret, 1);
        @(negedge clk);
        chk(a_wr_ret == 1, "R9 sender released", a_wr_ret, 1);
        chk(a_rd_data == 44, "R9 late value", a_rd_data, 44);
    endtask

    // reader alone waits, then a late sender
    task automatic t_reader_first();
        logic signed [7:0] prev;
        int bad;
        prev = a_rd_data;
        bad = 0;
        a_rd_tok = 1;
        @(negedge clk);
        a_rd_tok = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (a_rd_ret || a_ack || a_rd_data != prev) bad++;
        end
        chk(bad == 0, "R8 reader waits", bad, 0);
        a_wr_data = -77; a_wr_tok = 1;
        @(negedge clk);
        a_wr_tok = 0;
        chk(a_rd_ret == 1 && a_ack == 1, "R9 reader returns on offer", a_rd_ret, 1);
        @(negedge clk);
        chk(a_wr_ret == 1, "R9 sender return", a_wr_ret, 1);
        chk(a_rd_data == -77, "R9 value", a_rd_data, -77);
    endtask

    // two pairs chained sequentially on both sides
    task automatic t_sequence();
        int c_rda, c_wra, c_rdb, c_wrb;
        c_rda = -1; c_wra = -1; c_rdb = -1; c_wrb = -1;
        seq_mode = 1;
        b_wr_data = 91;
        a_wr_data = -3; a_wr_tok = 1; a_rd_tok = 1;
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            a_wr_tok = 0; a_rd_tok = 0;
            if (a_rd_ret && c_rda < 0) c_rda = k;
            if (a_wr_ret && c_wra < 0) c_wra = k;
            if (b_rd_ret && c_rdb < 0) c_rdb = k;
            if (b_wr_ret && c_wrb < 0) c_wrb = k;
        end
        chk(c_rda == 1 && c_wra == 2, "R9 first stage order", c_wra, 2);
        chk(c_rdb == 4, "R3 second reader return cycle", c_rdb, 4);
        chk(c_wrb == 5, "R4 second sender return cycle", c_wrb, 5);
        chk(a_rd_data == -3, "R5 first chain value", a_rd_data, -3);
        chk(b_rd_data == 91 && b_rd_vld == 1, "R5 second chain value", b_rd_data, 91);
        seq_mode = 0;
    endtask

    initial begin
        t_reset();
        t_parallel(-5, "negative");
        t_parallel(127, "max");
        t_parallel(-128, "min");
        t_deadlock();
        t_reader_first();
        t_reset();
        t_sequence();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule